// File: doc/BRIEF.md
# Serial Transmit Start and Frame-Sync Controller

This block sits beside the shift register of a synchronous serial transmitter. It decides in which cycle the transmitter begins shifting a new data word. It also derives a periodic frame-sync pulse from the transmit bit clock. All sequential logic advances on a transmit clock enable (`tck_en`) that marks one transmit clock period. The block therefore runs on the system clock and needs no second clock domain.

A 3-bit selector picks the start condition. The choices are:
- continuous operation, driven by holding-register writes and by the end of the previous transfer;
- the receiver's start event;
- a level, edge or any-change condition on the external frame-sync pin, which first passes through a two-flop synchronizer.

A start event is called a trigger. After a trigger, a programmable delay of `cfg_delay` transmit clocks runs before the start strobe is issued. While that delay is running, new triggers are ignored. When `cfg_period` is nonzero, the frame-sync generator emits a one-clock pulse every 2×(`cfg_period`+1) transmit clocks.

Top module: `tx_start_ctrl`

## Requirements
- R1: With `cfg_start_sel`=0, delay 0 and `tx_en` high, a one-cycle pulse on `hold_written` or on `xfer_done`, sampled on an enabled edge, yields `start_o` high in the cycle after that edge.
- R2: With `cfg_start_sel`=1, a pulse on `rx_start` yields `start_o` one transmit clock later when the delay is 0.
- R3: `cfg_start_sel`=2 starts on a low level of `fs_pin`, and `cfg_start_sel`=3 starts on a high level. Because of the two-flop synchronizer, with delay 0 `start_o` is high after the third clock edge following the pin change.
- R4: `cfg_start_sel` 4, 5, 6 and 7 start, respectively, on a falling edge, a rising edge, any change and any edge of the synchronized `fs_pin`, with the same three-edge latency. An edge in the other direction gives no start in modes 4 and 5.
- R5: A nonzero `cfg_delay` of D postpones `start_o` by exactly D transmit clocks relative to delay 0. This holds in every start mode, including the receiver-linked mode.
- R6: While a start delay is counting, further triggers are ignored, so one trigger yields exactly one `start_o` pulse.
- R7: `start_o` is never high in a cycle after `tx_en` was low. Dropping `tx_en` cancels a pending delayed start.
- R8: With `cfg_period`=0, `fs_o` stays low.
- R9: With `cfg_period`=P>0, `fs_o` is a single-cycle pulse every 2×(P+1) transmit clocks. The first pulse comes 2×(P+1) transmit clocks after `tx_en` rises, because the period count restarts whenever `tx_en` is low.
- R10: During reset, `start_o` and `fs_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tck_en | input | 1 | One-cycle enable marking each transmit clock period |
| tx_en | input | 1 | Transmitter enabled |
| hold_written | input | 1 | Holding register was written (pulse) |
| xfer_done | input | 1 | Previous word finished shifting (pulse) |
| rx_start | input | 1 | Receiver start event (pulse) |
| fs_pin | input | 1 | External frame-sync pin, asynchronous |
| cfg_period | input | 8 | Frame-sync period divider, 0 disables the pulse |
| cfg_delay | input | 8 | Start delay in transmit clocks |
| cfg_start_sel | input | 3 | Start-condition selector |
| start_o | output | 1 | Start-of-transmission strobe |
| fs_o | output | 1 | Periodic frame-sync pulse |

## Verification
A trigger from a one-cycle input pulse shows on `start_o` after the first clock edge, plus D further edges for a delay of D. A change on `fs_pin` needs three edges, plus D, because two of them pass through the synchronizer. The bench drives stimulus on the falling clock edge, counts rising edges and samples one time unit after each. Each vector's expected edge count therefore equals its table entry exactly. Frame-sync pulses are timed the same way: the first pulse is expected at rising edge 2×(P+1) after `tx_en` rises, and each later pulse 2×(P+1) enabled edges after the previous one.

// File: rtl/txs_pkg.sv
package txs_pkg;
  typedef enum logic [2:0] {
    SEL_CONT   = 3'd0,
    SEL_RX     = 3'd1,
    SEL_LOW    = 3'd2,
    SEL_HIGH   = 3'd3,
    SEL_FALL   = 3'd4,
    SEL_RISE   = 3'd5,
    SEL_CHANGE = 3'd6,
    SEL_EDGE   = 3'd7
  } start_sel_e;
endpackage

// File: rtl/txs_pin_sync.sv
module txs_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tck_en,
  input  logic pin,
  output logic level,
  output logic prev
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q, prev_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= pin;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  // previous-value copy only moves on transmit clock enable
  always_comb prev_d = tck_en ? chain_q[STAGES-1] : prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign level = chain_q[STAGES-1];
  assign prev  = prev_q;
endmodule

// File: rtl/txs_start_cond.sv
module txs_start_cond
  import txs_pkg::*;
(
  input  logic       tx_en,
  input  logic [2:0] sel,
  input  logic       hold_written,
  input  logic       xfer_done,
  input  logic       rx_start,
  input  logic       level,
  input  logic       prev,
  output logic       trig
);
  logic cond;

  always_comb begin
    case (start_sel_e'(sel))
      SEL_CONT:   cond = hold_written | xfer_done;
      SEL_RX:     cond = rx_start;
      SEL_LOW:    cond = ~level;
      SEL_HIGH:   cond = level;
      SEL_FALL:   cond = prev & ~level;
      SEL_RISE:   cond = ~prev & level;
      SEL_CHANGE: cond = prev ^ level;
      SEL_EDGE:   cond = prev ^ level;
      default:    cond = 1'b0;
    endcase
    trig = tx_en & cond;
  end
endmodule

// File: rtl/txs_start_delay.sv
module txs_start_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck_en,
  input  logic             tx_en,
  input  logic             trig,
  input  logic [DLY_W-1:0] delay,
  output logic             start_o
);
  logic             busy_q, busy_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    if (!tx_en) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (tck_en) begin
      if (busy_q) begin
        if (cnt_q == DLY_W'(1)) begin
          busy_d  = 1'b0;
          cnt_d   = '0;
          start_d = 1'b1;
        end else begin
          cnt_d = cnt_q - DLY_W'(1);
        end
      end else if (trig) begin
        if (delay == '0) start_d = 1'b1;
        else begin
          busy_d = 1'b1;
          cnt_d  = delay;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign start_o = start_q;

  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(tx_en)); // R7
  AST_DELAY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q > DLY_W'(1)) |=> !start_o); // R6
endmodule

// File: rtl/txs_fsync_gen.sv
module txs_fsync_gen #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck_en,
  input  logic             tx_en,
  input  logic [PER_W-1:0] period,
  output logic             fs_o
);
  localparam int CNT_W = PER_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last;
  logic             run;
  logic             fs_q, fs_d;

  // 2*(P+1) states: count 0 .. 2P+1
  assign last = {period, 1'b1};
  assign run  = tx_en && (period != '0);

  always_comb begin
    cnt_d = cnt_q;
    fs_d  = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (tck_en) begin
      if (cnt_q >= last) begin
        cnt_d = '0;
        fs_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fs_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fs_q  <= fs_d;
    end
  end

  assign fs_o = fs_q;

  AST_NO_FS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (period == '0) |=> !fs_o); // R8
  AST_FS_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    fs_o |=> !fs_o); // R9
endmodule

// File: rtl/tx_start_ctrl.sv
module tx_start_ctrl #(
  parameter int PER_W       = 8,
  parameter int DLY_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tck_en,
  input  logic             tx_en,
  input  logic             hold_written,
  input  logic             xfer_done,
  input  logic             rx_start,
  input  logic             fs_pin,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [2:0]       cfg_start_sel,
  output logic             start_o,
  output logic             fs_o
);
  logic pin_level, pin_prev, trig;

  txs_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .tck_en(tck_en), .pin(fs_pin),
    .level(pin_level), .prev(pin_prev)
  );

  txs_start_cond u_cond (
    .tx_en(tx_en), .sel(cfg_start_sel), .hold_written(hold_written),
    .xfer_done(xfer_done), .rx_start(rx_start), .level(pin_level),
    .prev(pin_prev), .trig(trig)
  );

  txs_start_delay #(.DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .tck_en(tck_en), .tx_en(tx_en),
    .trig(trig), .delay(cfg_delay), .start_o(start_o)
  );

  txs_fsync_gen #(.PER_W(PER_W)) u_fsync (
    .clk(clk), .rst_n(rst_n), .tck_en(tck_en), .tx_en(tx_en),
    .period(cfg_period), .fs_o(fs_o)
  );
endmodule

// File: tb/test_tx_start_ctrl.sv
module test_tx_start_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, tck_en, tx_en, hold_written, xfer_done, rx_start, fs_pin;
  logic [7:0] cfg_period, cfg_delay;
  logic [2:0] cfg_start_sel;
  logic       start_o, fs_o;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  tx_start_ctrl i_tx_start_ctrl (
    .clk(clk), .rst_n(rst_n), .tck_en(tck_en), .tx_en(tx_en),
    .hold_written(hold_written), .xfer_done(xfer_done), .rx_start(rx_start),
    .fs_pin(fs_pin), .cfg_period(cfg_period), .cfg_delay(cfg_delay),
    .cfg_start_sel(cfg_start_sel), .start_o(start_o), .fs_o(fs_o)
  );

  // {sel[3], delay[8], stim[3], expected edges[9]}
  // stim: 0 hold_written, 1 xfer_done, 2 rx_start, 3 pin 1->0, 4 pin 0->1
  localparam logic [22:0] VECS [12] = '{
    {3'd0, 8'd0, 3'd0, 9'd1},  // R1
    {3'd0, 8'd5, 3'd1, 9'd6},  // R1 R5
    {3'd1, 8'd0, 3'd2, 9'd1},  // R2
    {3'd1, 8'd3, 3'd2, 9'd4},  // R2 R5
    {3'd2, 8'd0, 3'd3, 9'd3},  // R3
    {3'd3, 8'd2, 3'd4, 9'd5},  // R3 R5
    {3'd4, 8'd0, 3'd3, 9'd3},  // R4
    {3'd5, 8'd1, 3'd4, 9'd4},  // R4 R5
    {3'd6, 8'd0, 3'd4, 9'd3},  // R4
    {3'd6, 8'd0, 3'd3, 9'd3},  // R4
    {3'd7, 8'd4, 3'd3, 9'd7},  // R4 R5
    {3'd7, 8'd0, 3'd4, 9'd3}   // R4
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bring the block idle with the pin preset
  task automatic prepare(input logic [2:0] sel, input logic [7:0] dly, input logic pin0);
    @(negedge clk);
    tx_en = 1'b0; hold_written = 0; xfer_done = 0; rx_start = 0;
    fs_pin = pin0; cfg_start_sel = sel; cfg_delay = dly; cfg_period = '0;
    repeat (4) @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic stimulus(input logic [2:0] stim);
    case (stim)
      3'd0: hold_written = 1'b1;
      3'd1: xfer_done    = 1'b1;
      3'd2: rx_start     = 1'b1;
      3'd3: fs_pin       = 1'b0;
      default: fs_pin    = 1'b1;
    endcase
  endtask

  // first rising edge (counted from the stimulus) at which start_o is seen, and pulse count
  task automatic observe(input int span, input int repulse_at, output int first, output int cnt);
    first = 0; cnt = 0;
    for (int n = 1; n <= span; n++) begin
      @(posedge clk); #1;
      hold_written = 0; xfer_done = 0; rx_start = 0;
      if (start_o) begin
        cnt++;
        if (first == 0) first = n;
      end
      if (n == repulse_at) rx_start = 1'b1;
    end
  endtask

  task automatic fs_run(input logic [7:0] per, input bit gate, input int span,
                        output int first, output int spacing, output int cnt, output int wide);
    int last_pulse;
    bit prev_fs;
    first = 0; spacing = 0; cnt = 0; wide = 0; last_pulse = 0; prev_fs = 0;
    @(negedge clk);
    tx_en = 1'b0; cfg_period = per; cfg_start_sel = 3'd1; rx_start = 0;
    repeat (2) @(negedge clk);
    tx_en = 1'b1;
    for (int n = 1; n <= span; n++) begin
      tck_en = gate ? n[0] : 1'b1;
      @(posedge clk); #1;
      if (fs_o) begin
        cnt++;
        if (prev_fs) wide++;
        if (first == 0) first = n;
        else if (spacing == 0) spacing = n - last_pulse;
        last_pulse = n;
      end
      prev_fs = fs_o;
      @(negedge clk);
    end
    tck_en = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int first, cnt, spacing, wide;
    rst_n = 0; tck_en = 1; tx_en = 0; hold_written = 0; xfer_done = 0;
    rx_start = 0; fs_pin = 0; cfg_period = 8'd3; cfg_delay = 0; cfg_start_sel = 0;
    repeat (3) @(posedge clk);
    #1;
    check(!start_o && !fs_o, "R10 reset outputs", {start_o, fs_o}, 0);
    @(negedge clk); rst_n = 1;

    // table walk
    for (int i = 0; i < 12; i++) begin
      logic [22:0] v;
      v = VECS[i];
      prepare(v[22:20], v[19:12], (v[11:9] == 3'd3));
      stimulus(v[11:9]);
      observe(12, 0, first, cnt);
      check(first == int'(v[8:0]), $sformatf("R1-R5 vector %0d (R5 latency)", i),
            first, int'(v[8:0]));
    end

    // R7: no start with transmit disabled
    prepare(3'd0, 8'd0, 1'b0);
    tx_en = 1'b0; hold_written = 1'b1;
    observe(10, 0, first, cnt);
    check(cnt == 0, "R7 no start while tx_en low", cnt, 0);

    // R7: dropping tx_en cancels a pending delayed start
    prepare(3'd1, 8'd6, 1'b0);
    rx_start = 1'b1;
    observe(3, 0, first, cnt);
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk); tx_en = 1'b1;
    observe(15, 0, first, cnt);
    check(cnt == 0, "R7 pending start cancelled", cnt, 0);

    // R4: wrong-direction edge in rising mode, then in falling mode
    prepare(3'd5, 8'd0, 1'b1);
    fs_pin = 1'b0;
    observe(10, 0, first, cnt);
    check(cnt == 0, "R4 falling edge ignored in rising mode", cnt, 0);
    prepare(3'd4, 8'd0, 1'b0);
    fs_pin = 1'b1;
    observe(10, 0, first, cnt);
    check(cnt == 0, "R4 rising edge ignored in falling mode", cnt, 0);

    // R6: trigger during delay is ignored
    prepare(3'd1, 8'd10, 1'b0);
    rx_start = 1'b1;
    observe(30, 4, first, cnt);
    check(first == 11, "R6 delayed start latency", first, 11);
    check(cnt == 1, "R6 single start per trigger", cnt, 1);

    // R8: period zero
    fs_run(8'd0, 1'b0, 200, first, spacing, cnt, wide);
    check(cnt == 0, "R8 no frame sync at period 0", cnt, 0);

    // R9: period 3 -> every 8 clocks
    fs_run(8'd3, 1'b0, 100, first, spacing, cnt, wide);
    check(first == 8, "R9 first pulse P=3", first, 8);
    check(spacing == 8, "R9 spacing P=3", spacing, 8);
    check(cnt == 12, "R9 pulse count P=3", cnt, 12);
    check(wide == 0, "R9 pulse width", wide, 0);
    // restart after tx_en low (previous run stopped mid-count)
    fs_run(8'd3, 1'b0, 20, first, spacing, cnt, wide);
    check(first == 8, "R9 count restarts after tx_en low", first, 8);

    // R9: maximum period
    fs_run(8'd255, 1'b0, 1100, first, spacing, cnt, wide);
    check(first == 512, "R9 first pulse P=255", first, 512);
    check(spacing == 512, "R9 spacing P=255", spacing, 512);

    // R9: transmit clock enable every other cycle, P=1 -> 4 tck = 8 clocks
    fs_run(8'd1, 1'b1, 60, first, spacing, cnt, wide);
    check(spacing == 8, "R9 spacing with gated tck_en", spacing, 8);
    check(wide == 0, "R9 width with gated tck_en", wide, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule